// File: doc/BRIEF.md
# Private Cache Read-Miss Coherence Controller

This block keeps the coherence state of a small set of lines in a private cache level that sits between an inner cache and a directory-managed outer level. An inner load to a line that is not held sends a shared-read request outward and marks the line as waiting. A fill that arrives while waiting is returned to the inner cache as normal data, and the line becomes shared. Later loads to that line are then answered from the stored copy.

The key case is an invalidate-all message that reaches a line whose read miss is still in flight. The controller answers that invalidation with an acknowledgement at once and does not wait for the data. When the late fill arrives, it is handed to the inner cache exactly once, flagged as stale, and the line falls back to invalid. Because the acknowledgement is never held back behind a pending read, another core's exclusive request can always complete.

Each accepted input produces its state change and its output pulses in one registered cycle. Loads use a valid/ready handshake and are held off while their line is waiting. Messages are always accepted.

Top module: `rmc_miss_ctrl`

## Requirements
- R1: After reset every line is invalid, no output pulse is raised, and a load to any line is accepted.
- R2: An accepted load to an invalid line raises `gets_valid` with that line on `gets_line` in the next cycle, and the line enters the waiting state.
- R3: A fill (`msg_kind` = 1) to a waiting line returns its data in the next cycle with `rsp_stale` = 0, and the line becomes shared. A later load to a shared line returns the stored data with `rsp_stale` = 0 and sends no read request.
- R4: An invalidate-all (`msg_kind` = 0) to a waiting line raises `ack_valid` for that line in the next cycle, without waiting for the fill, and marks the line killed-while-waiting.
- R5: A fill to a killed-while-waiting line is returned in the next cycle with `rsp_stale` = 1, and the line becomes invalid, so the next load to it sends a new read request.
- R6: An invalidate-all to a shared line is acknowledged and leaves the line invalid. An invalidate-all to an invalid line is acknowledged and leaves the line invalid.
- R7: `req_ready` is low for a load whose line is waiting or killed-while-waiting, and no request or response results from that load.
- R8: A load is held off (`req_ready` low) when a message to the same line is presented in the same cycle, or when the load would hit a shared line while a fill response uses the response port.
- R9: `msg_ready` is always high. A fill to an invalid or shared line produces no response and changes no state.
- R10: The acknowledgement, read-request and response outputs work independently: events on different lines in one cycle each appear with their own line number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Inner load request present |
| req_ready | output | 1 | Load accepted this cycle |
| req_line | input | IW | Line addressed by the load |
| msg_valid | input | 1 | Outer message present |
| msg_ready | output | 1 | Message accepted (always 1) |
| msg_kind | input | 1 | 0 = invalidate-all, 1 = fill data |
| msg_line | input | IW | Line addressed by the message |
| msg_data | input | DW | Fill payload |
| gets_valid | output | 1 | Shared-read request pulse to the outer level |
| gets_line | output | IW | Line of the read request |
| ack_valid | output | 1 | Invalidation acknowledgement pulse |
| ack_line | output | IW | Line being acknowledged |
| rsp_valid | output | 1 | Data response pulse to the inner cache |
| rsp_line | output | IW | Line of the response |
| rsp_data | output | DW | Response data |
| rsp_stale | output | 1 | 1 when the data may be used once only and is not kept |

## Verification
Two functions can fall in the same cycle: an inner load and an outer message. They can address the same line, or they can both want the response port, when a shared-line hit meets a fill to a waiting line. The bench drives every ordered pair of lines with a load and a message of each kind together, then runs a long pseudo-random mix of both. A line-state model in the bench predicts `req_ready` and every output pulse. It judges that the same-line and port-conflict cases stall the load, and that acknowledgements and read requests on different lines both emerge in the same cycle with the right line numbers.

// File: rtl/rmc_pkg.sv
package rmc_pkg;

    typedef enum logic [1:0] {
        LN_INV         = 2'd0,
        LN_SHR         = 2'd1,
        LN_WAIT        = 2'd2,
        LN_WAIT_KILLED = 2'd3
    } line_st_e;

    typedef enum logic {
        MSG_INVALL = 1'b0,
        MSG_FILL   = 1'b1
    } msg_kind_e;

endpackage

// File: rtl/rmc_line.sv
module rmc_line
    import rmc_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_fire,
    input  logic          msg_hit,
    input  msg_kind_e     msg_kind,
    input  logic [DW-1:0] msg_data,
    output line_st_e      st_o,
    output logic          ev_gets,
    output logic          ev_ack,
    output logic          ev_rsp,
    output logic          ev_stale,
    output logic [DW-1:0] ev_data
);

    typedef struct packed {
        line_st_e      st;
        logic [DW-1:0] data;
    } line_reg_t;

    line_reg_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        ev_gets  = 1'b0;
        ev_ack   = 1'b0;
        ev_rsp   = 1'b0;
        ev_stale = 1'b0;
        ev_data  = r_q.data;

        if (msg_hit) begin
            if (msg_kind == MSG_INVALL) begin
                ev_ack = 1'b1;
                case (r_q.st)
                    LN_WAIT: r_d.st = LN_WAIT_KILLED;
                    LN_SHR:  r_d.st = LN_INV;
                    default: r_d.st = r_q.st;
                endcase
            end else begin
                case (r_q.st)
                    LN_WAIT: begin
                        r_d.st   = LN_SHR;
                        r_d.data = msg_data;
                        ev_rsp   = 1'b1;
                        ev_data  = msg_data;
                    end
                    LN_WAIT_KILLED: begin
                        r_d.st   = LN_INV;
                        ev_rsp   = 1'b1;
                        ev_stale = 1'b1;
                        ev_data  = msg_data;
                    end
                    default: r_d.st = r_q.st;
                endcase
            end
        end

        if (req_fire) begin
            case (r_q.st)
                LN_INV: begin
                    r_d.st  = LN_WAIT;
                    ev_gets = 1'b1;
                end
                LN_SHR: begin
                    ev_rsp  = 1'b1;
                    ev_data = r_q.data;
                end
                default: r_d.st = r_q.st;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: LN_INV, data: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign st_o = r_q.st;

    // R4: invalidation during a pending miss marks the line killed
    p_inv_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == LN_WAIT && msg_hit && msg_kind == MSG_INVALL) |=> (r_q.st == LN_WAIT_KILLED));

    // R5: late fill after invalidation leaves the line invalid
    p_stale_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == LN_WAIT_KILLED && msg_hit && msg_kind == MSG_FILL) |=> (r_q.st == LN_INV));

    // R3: normal fill installs the payload
    p_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == LN_WAIT && msg_hit && msg_kind == MSG_FILL)
        |=> (r_q.st == LN_SHR && r_q.data == $past(msg_data)));

    // R7: the handshake never lets a load into a pending line
    p_pending_nofire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_fire |-> (r_q.st == LN_INV || r_q.st == LN_SHR));

    // R8: load and message never reach the same line together
    p_no_collide_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_fire && msg_hit));

endmodule

// File: rtl/rmc_out_reg.sv
module rmc_out_reg #(
    parameter int IW = 2,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gets_v_d,
    input  logic [IW-1:0] gets_line_d,
    input  logic          ack_v_d,
    input  logic [IW-1:0] ack_line_d,
    input  logic          rsp_v_d,
    input  logic [IW-1:0] rsp_line_d,
    input  logic          rsp_stale_d,
    input  logic [DW-1:0] rsp_data_d,
    output logic          gets_v_q,
    output logic [IW-1:0] gets_line_q,
    output logic          ack_v_q,
    output logic [IW-1:0] ack_line_q,
    output logic          rsp_v_q,
    output logic [IW-1:0] rsp_line_q,
    output logic          rsp_stale_q,
    output logic [DW-1:0] rsp_data_q
);

    typedef struct packed {
        logic          gets_v;
        logic [IW-1:0] gets_line;
        logic          ack_v;
        logic [IW-1:0] ack_line;
        logic          rsp_v;
        logic [IW-1:0] rsp_line;
        logic          rsp_stale;
        logic [DW-1:0] rsp_data;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d.gets_v    = gets_v_d;
        o_d.gets_line = gets_line_d;
        o_d.ack_v     = ack_v_d;
        o_d.ack_line  = ack_line_d;
        o_d.rsp_v     = rsp_v_d;
        o_d.rsp_line  = rsp_line_d;
        o_d.rsp_stale = rsp_stale_d;
        o_d.rsp_data  = rsp_data_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign gets_v_q    = o_q.gets_v;
    assign gets_line_q = o_q.gets_line;
    assign ack_v_q     = o_q.ack_v;
    assign ack_line_q  = o_q.ack_line;
    assign rsp_v_q     = o_q.rsp_v;
    assign rsp_line_q  = o_q.rsp_line;
    assign rsp_stale_q = o_q.rsp_stale;
    assign rsp_data_q  = o_q.rsp_data;

endmodule

// File: rtl/rmc_miss_ctrl.sv
module rmc_miss_ctrl
    import rmc_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int DW        = 32,
    localparam int IW       = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [IW-1:0] req_line,
    input  logic          msg_valid,
    output logic          msg_ready,
    input  logic          msg_kind,
    input  logic [IW-1:0] msg_line,
    input  logic [DW-1:0] msg_data,
    output logic          gets_valid,
    output logic [IW-1:0] gets_line,
    output logic          ack_valid,
    output logic [IW-1:0] ack_line,
    output logic          rsp_valid,
    output logic [IW-1:0] rsp_line,
    output logic [DW-1:0] rsp_data,
    output logic          rsp_stale
);

    msg_kind_e mk;
    assign mk = msg_kind_e'(msg_kind);

    line_st_e            st      [NUM_LINES];
    logic [NUM_LINES-1:0] req_fire;
    logic [NUM_LINES-1:0] msg_hit;
    logic [NUM_LINES-1:0] ev_gets;
    logic [NUM_LINES-1:0] ev_ack;
    logic [NUM_LINES-1:0] ev_rsp;
    logic [NUM_LINES-1:0] ev_stale;
    logic [DW-1:0]        ev_data [NUM_LINES];

    line_st_e req_st, msg_st;
    logic     req_line_ok, msg_line_ok, msg_makes_rsp;

    always_comb begin
        req_st      = LN_INV;
        msg_st      = LN_INV;
        req_line_ok = 1'b0;
        msg_line_ok = 1'b0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (req_line == IW'(i)) begin
                req_st      = st[i];
                req_line_ok = 1'b1;
            end
            if (msg_line == IW'(i)) begin
                msg_st      = st[i];
                msg_line_ok = 1'b1;
            end
        end
        msg_makes_rsp = msg_valid && msg_line_ok && (mk == MSG_FILL)
                        && (msg_st == LN_WAIT || msg_st == LN_WAIT_KILLED);
        req_ready = req_line_ok
                    && (req_st == LN_INV || req_st == LN_SHR)
                    && !(msg_valid && msg_line == req_line)
                    && !(req_st == LN_SHR && msg_makes_rsp);
    end

    assign msg_ready = 1'b1;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        localparam logic [IW-1:0] LIDX = IW'(g);
        assign req_fire[g] = req_valid && req_ready && (req_line == LIDX);
        assign msg_hit[g]  = msg_valid && (msg_line == LIDX);

        rmc_line #(.DW(DW)) u_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_fire (req_fire[g]),
            .msg_hit  (msg_hit[g]),
            .msg_kind (mk),
            .msg_data (msg_data),
            .st_o     (st[g]),
            .ev_gets  (ev_gets[g]),
            .ev_ack   (ev_ack[g]),
            .ev_rsp   (ev_rsp[g]),
            .ev_stale (ev_stale[g]),
            .ev_data  (ev_data[g])
        );
    end

    logic          gets_v_d, ack_v_d, rsp_v_d, rsp_stale_d;
    logic [IW-1:0] gets_line_d, ack_line_d, rsp_line_d;
    logic [DW-1:0] rsp_data_d;

    always_comb begin
        gets_v_d    = 1'b0;
        gets_line_d = '0;
        ack_v_d     = 1'b0;
        ack_line_d  = '0;
        rsp_v_d     = 1'b0;
        rsp_line_d  = '0;
        rsp_stale_d = 1'b0;
        rsp_data_d  = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (ev_gets[i]) begin
                gets_v_d    = 1'b1;
                gets_line_d = IW'(i);
            end
            if (ev_ack[i]) begin
                ack_v_d    = 1'b1;
                ack_line_d = IW'(i);
            end
            if (ev_rsp[i]) begin
                rsp_v_d     = 1'b1;
                rsp_line_d  = IW'(i);
                rsp_stale_d = ev_stale[i];
                rsp_data_d  = ev_data[i];
            end
        end
    end

    rmc_out_reg #(.IW(IW), .DW(DW)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .gets_v_d    (gets_v_d),
        .gets_line_d (gets_line_d),
        .ack_v_d     (ack_v_d),
        .ack_line_d  (ack_line_d),
        .rsp_v_d     (rsp_v_d),
        .rsp_line_d  (rsp_line_d),
        .rsp_stale_d (rsp_stale_d),
        .rsp_data_d  (rsp_data_d),
        .gets_v_q    (gets_valid),
        .gets_line_q (gets_line),
        .ack_v_q     (ack_valid),
        .ack_line_q  (ack_line),
        .rsp_v_q     (rsp_valid),
        .rsp_line_q  (rsp_line),
        .rsp_stale_q (rsp_stale),
        .rsp_data_q  (rsp_data)
    );

    // R4/R6: every invalidation is acknowledged one cycle later for its line
    p_ack_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_line_ok && mk == MSG_INVALL)
        |=> (ack_valid && ack_line == $past(msg_line)));

    // R2: accepted load to an invalid line issues a read request next cycle
    p_gets_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_st == LN_INV)
        |=> (gets_valid && gets_line == $past(req_line)));

    // R8: never two lines competing for the response port
    p_one_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ev_rsp) <= 1);

endmodule

// File: tb/rmc_miss_ctrl_tb.sv
module rmc_miss_ctrl_tb;

    localparam int NL = 4;
    localparam int DW = 8;
    localparam int IW = 2;
    // model states: 0 invalid, 1 shared, 2 waiting, 3 killed-while-waiting
    localparam int S_I = 0, S_S = 1, S_W = 2, S_K = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [IW-1:0] req_line = '0;
    logic          msg_valid = 1'b0;
    logic          msg_ready;
    logic          msg_kind = 1'b0;
    logic [IW-1:0] msg_line = '0;
    logic [DW-1:0] msg_data = '0;
    logic          gets_valid, ack_valid, rsp_valid, rsp_stale;
    logic [IW-1:0] gets_line, ack_line, rsp_line;
    logic [DW-1:0] rsp_data;

    always #2 clk = ~clk;

    rmc_miss_ctrl #(.NUM_LINES(NL), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_line(req_line),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
        .msg_line(msg_line), .msg_data(msg_data),
        .gets_valid(gets_valid), .gets_line(gets_line),
        .ack_valid(ack_valid), .ack_line(ack_line),
        .rsp_valid(rsp_valid), .rsp_line(rsp_line),
        .rsp_data(rsp_data), .rsp_stale(rsp_stale)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int mst [NL];
    logic [DW-1:0] mdat [NL];
    logic [31:0] lf = 32'h1234_5678;

    task automatic chk(input bit ok, input string tag, input string ctx, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s (%s): actual %0d expected %0d", tag, ctx, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] v);
        logic [31:0] x;
        x = v ^ (v << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // starts and ends at a falling edge
    task automatic cyc(input bit rv, input int rl, input bit mv, input bit mk,
                       input int ml, input logic [DW-1:0] md, input string ctx);
        bit e_rdy, e_gets, e_ack, e_rsp, e_stale, fire, m_rsp;
        int e_rsp_line;
        logic [DW-1:0] e_data;
        req_valid = rv; req_line = IW'(rl);
        msg_valid = mv; msg_kind = mk; msg_line = IW'(ml); msg_data = md;
        #1;
        m_rsp = mv && mk && (mst[ml] == S_W || mst[ml] == S_K);
        e_rdy = (mst[rl] == S_I || mst[rl] == S_S) && !(mv && ml == rl)
                && !(mst[rl] == S_S && m_rsp);
        chk(req_ready == e_rdy, (mst[rl] >= S_W) ? "R7" : "R8", ctx, req_ready, e_rdy);
        chk(msg_ready == 1'b1, "R9", ctx, msg_ready, 1);
        fire = rv && e_rdy;
        e_gets = fire && mst[rl] == S_I;
        e_ack = mv && !mk;
        e_rsp = 1'b0; e_stale = 1'b0; e_data = '0; e_rsp_line = 0;
        if (m_rsp) begin
            e_rsp = 1'b1; e_stale = (mst[ml] == S_K); e_data = md; e_rsp_line = ml;
        end
        if (fire && mst[rl] == S_S) begin
            e_rsp = 1'b1; e_stale = 1'b0; e_data = mdat[rl]; e_rsp_line = rl;
        end
        // model update
        if (mv) begin
            if (!mk) begin
                if (mst[ml] == S_W) mst[ml] = S_K;
                else if (mst[ml] == S_S) mst[ml] = S_I;
            end else begin
                if (mst[ml] == S_W) begin mst[ml] = S_S; mdat[ml] = md; end
                else if (mst[ml] == S_K) mst[ml] = S_I;
            end
        end
        if (fire && mst[rl] == S_I) mst[rl] = S_W;
        @(posedge clk);
        @(negedge clk);
        chk(gets_valid == e_gets, "R2", ctx, gets_valid, e_gets);
        if (e_gets) chk(gets_line == IW'(rl), "R10", ctx, gets_line, rl);
        chk(ack_valid == e_ack, "R4", ctx, ack_valid, e_ack);
        if (e_ack) chk(ack_line == IW'(ml), "R10", ctx, ack_line, ml);
        chk(rsp_valid == e_rsp, e_stale ? "R5" : "R3", ctx, rsp_valid, e_rsp);
        if (e_rsp) begin
            chk(rsp_stale == e_stale, "R5", ctx, rsp_stale, e_stale);
            chk(rsp_data == e_data, e_stale ? "R5" : "R3", ctx, rsp_data, e_data);
            chk(rsp_line == IW'(e_rsp_line), "R10", ctx, rsp_line, e_rsp_line);
        end
        req_valid = 1'b0; msg_valid = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < NL; i++) begin mst[i] = S_I; mdat[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(!gets_valid && !ack_valid && !rsp_valid, "R1", "reset outputs", 
            {gets_valid, ack_valid, rsp_valid}, 0);
        for (int l = 0; l < NL; l++) begin
            req_line = IW'(l); req_valid = 1'b1; #0.1;
            chk(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
        end
        req_valid = 1'b0;
        @(negedge clk);

        // R4/R5 deadlock scenario: miss, invalidate, stalled load, stale fill, refetch
        cyc(1, 1, 0, 0, 0, 8'h00, "R2 miss line1");
        cyc(0, 0, 1, 0, 1, 8'h00, "R4 inv while waiting");
        cyc(1, 1, 0, 0, 0, 8'h00, "R7 load on killed line");
        cyc(0, 0, 1, 1, 1, 8'hA5, "R5 stale fill");
        cyc(1, 1, 0, 0, 0, 8'h00, "R5 line invalid refetch");
        cyc(0, 0, 1, 1, 1, 8'h3C, "R3 normal fill");
        cyc(1, 1, 0, 0, 0, 8'h00, "R3 hit after fill");
        cyc(0, 0, 1, 0, 1, 8'h00, "R6 inv shared");
        cyc(0, 0, 1, 0, 1, 8'h00, "R6 inv invalid");
        cyc(1, 1, 0, 0, 0, 8'h00, "R6 refetch after inv");
        cyc(0, 0, 1, 1, 2, 8'h77, "R9 fill to invalid line");
        cyc(1, 2, 0, 0, 0, 8'h00, "R9 line still invalid");
        cyc(1, 3, 1, 1, 1, 8'h11, "R10 miss + fill");
        cyc(0, 0, 1, 1, 1, 8'h99, "R9 fill to shared line");
        cyc(1, 1, 0, 0, 0, 8'h00, "R9 shared data kept");
        cyc(1, 1, 1, 1, 2, 8'h42, "R8 hit vs fill port");
        cyc(1, 0, 1, 0, 0, 8'h00, "R8 same line");

        // sweep every line pair with both message kinds
        for (int a = 0; a < NL; a++)
            for (int b = 0; b < NL; b++)
                for (int k = 0; k < 2; k++) begin
                    lf = nxt(lf);
                    cyc(1, a, 1, k[0], b, lf[7:0], "R10 concurrent sweep");
                end

        // pseudo-random mix
        for (int n = 0; n < 4000; n++) begin
            lf = nxt(lf);
            cyc(lf[0], int'(lf[2:1]), lf[3] | lf[4], lf[5], int'(lf[7:6]), lf[15:8], "random mix");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule